// File: doc/BRIEF.md
# Timer Output Compare Unit

This block sits beside an 8-bit timer/counter. It watches the counter value and compares it with a programmable compare value. When the two are equal on a timer tick, it raises a sticky compare flag and updates an output-compare state bit. The update sets, clears or toggles the bit, as chosen by a 2-bit mode field. A non-zero mode also tells the port logic that the compare unit now owns the pin.

Software may write the compare value, force a compare action and clear the flag. Each CPU write to the counter masks the next timer tick's compare. In PWM operation the compare value is held in a buffer and moves into the active register only on an update strobe. The mode field is never buffered.

Top module: `tmr_ocu`

## Requirements
- R1: After reset the flag is 0, the output-compare state is 0, the active compare value is 0 and no block is pending.
- R2: A match occurs in a cycle where `tick` is 1, `cnt_val` equals the active compare value, no block is pending and `cnt_wr` is 0. The flag reads 1 after the next rising edge.
- R3: The flag stays 1 until a cycle with `flag_clr` = 1 clears it. If a match and `flag_clr` fall in the same cycle, the flag stays set.
- R4: `cnt_wr` = 1 suppresses a match in its own cycle. It also arms a block that suppresses the match of the next cycle with `tick` = 1. Cycles with `tick` = 0 leave the block armed.
- R5: On a match, `mode` selects the action on the state bit: 2'b00 leaves it unchanged, 2'b01 toggles it, 2'b10 clears it to 0 and 2'b11 sets it to 1. This applies in both PWM and non-PWM operation.
- R6: With `pwm_mode` = 0, `force_stb` = 1 applies the R5 action without setting the flag and is not blocked by R4. A force and a real match in the same cycle apply the action once. With `pwm_mode` = 1, `force_stb` has no effect.
- R7: With `pwm_mode` = 0, a compare write changes the active compare value from the next cycle on. `update_stb` has no effect in this mode.
- R8: With `pwm_mode` = 1, a compare write goes only to the buffer. The active value takes the buffer content on a cycle with `update_stb` = 1. A write in that same cycle goes to the buffer and is not copied.
- R9: `pin_ovr` is 1 exactly while `mode` is non-zero, with no cycle of delay. A new `mode` governs the match or force of the very cycle it is presented in.
- R10: With `pwm_mode` = 1 and no match in the cycle, `update_stb` sets the state bit for mode 2'b10 and clears it for mode 2'b11. Modes 2'b00 and 2'b01 leave it unchanged. A match in the same cycle takes precedence.
- R11: Changing `pwm_mode` leaves the state bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable |
| cnt_val | input | W | Current counter value |
| cnt_wr | input | 1 | CPU write to counter strobe |
| cmp_wr | input | 1 | CPU write to compare value |
| cmp_wdata | input | W | Compare write data |
| force_stb | input | 1 | Force-compare strobe |
| pwm_mode | input | 1 | 1 = PWM operation (buffered compare) |
| update_stb | input | 1 | TOP/BOTTOM update strobe |
| mode | input | 2 | Compare-output action select |
| flag_clr | input | 1 | Write-one-to-clear of the flag |
| cmp_flag | output | 1 | Sticky compare-match flag |
| oc_state | output | 1 | Output-compare state bit |
| pin_ovr | output | 1 | Compare unit owns the pin |

## Verification
Several pairs of functions can meet in one cycle. The main ones are a force strobe with a real match, a counter write with an equal count, a flag clear with a match, and a PWM update with a match. Directed sequences line each pair up on purpose. Constrained random traffic over a small counter range makes such collisions frequent. Every result is judged against a bench model that applies the stated precedence: a single action, a suppressed match, the flag kept set, and the match action winning.

// File: rtl/tmr_ocu_pkg.sv
package tmr_ocu_pkg;
  typedef enum logic [1:0] {
    OCM_OFF = 2'b00,
    OCM_TOG = 2'b01,
    OCM_CLR = 2'b10,
    OCM_SET = 2'b11
  } ocm_e;
endpackage

// File: rtl/ocu_cmp_regs.sv
module ocu_cmp_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         pwm_mode,
  input  logic         update_stb,
  output logic [W-1:0] act_cmp
);
  logic [W-1:0] act_q, act_d, buf_q, buf_d;

  always_comb begin
    buf_d = buf_q;
    act_d = act_q;
    if (cmp_wr) buf_d = cmp_wdata;
    if (pwm_mode) begin
      if (update_stb) act_d = buf_q;
    end else if (cmp_wr) begin
      act_d = cmp_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      buf_q <= '0;
    end else begin
      act_q <= act_d;
      buf_q <= buf_d;
    end
  end

  assign act_cmp = act_q;
endmodule

// File: rtl/ocu_match.sv
module ocu_match #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt_val,
  input  logic         cnt_wr,
  input  logic [W-1:0] act_cmp,
  output logic         hit
);
  logic blk_q, blk_d;

  always_comb begin
    hit   = tick && (cnt_val == act_cmp) && !blk_q && !cnt_wr;
    blk_d = cnt_wr | (blk_q & ~tick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_q <= 1'b0;
    else        blk_q <= blk_d;
  end
endmodule

// File: rtl/ocu_wave.sv
module ocu_wave
  import tmr_ocu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       force_stb,
  input  logic       pwm_mode,
  input  logic       update_stb,
  input  logic [1:0] mode,
  input  logic       flag_clr,
  output logic       cmp_flag,
  output logic       oc_state
);
  logic flag_q, flag_d, oc_q, oc_d, fire;
  ocm_e md;

  always_comb begin
    md   = ocm_e'(mode);
    fire = hit | (force_stb & ~pwm_mode);
    oc_d = oc_q;
    if (fire) begin
      case (md)
        OCM_TOG: oc_d = ~oc_q;
        OCM_CLR: oc_d = 1'b0;
        OCM_SET: oc_d = 1'b1;
        default: oc_d = oc_q;
      endcase
    end else if (pwm_mode && update_stb) begin
      case (md)
        OCM_CLR: oc_d = 1'b1;
        OCM_SET: oc_d = 1'b0;
        default: oc_d = oc_q;
      endcase
    end
    if (hit)           flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      oc_q   <= 1'b0;
    end else begin
      flag_q <= flag_d;
      oc_q   <= oc_d;
    end
  end

  assign cmp_flag = flag_q;
  assign oc_state = oc_q;
endmodule

// File: rtl/tmr_ocu.sv
module tmr_ocu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt_val,
  input  logic         cnt_wr,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         force_stb,
  input  logic         pwm_mode,
  input  logic         update_stb,
  input  logic [1:0]   mode,
  input  logic         flag_clr,
  output logic         cmp_flag,
  output logic         oc_state,
  output logic         pin_ovr
);
  logic [1:0]   rs_q;
  logic         rst_i;
  logic [W-1:0] act_cmp;
  logic         hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  ocu_cmp_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_i), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .pwm_mode(pwm_mode), .update_stb(update_stb), .act_cmp(act_cmp)
  );

  ocu_match #(.W(W)) u_match (
    .clk(clk), .rst_n(rst_i), .tick(tick), .cnt_val(cnt_val),
    .cnt_wr(cnt_wr), .act_cmp(act_cmp), .hit(hit)
  );

  ocu_wave u_wave (
    .clk(clk), .rst_n(rst_i), .hit(hit), .force_stb(force_stb),
    .pwm_mode(pwm_mode), .update_stb(update_stb), .mode(mode),
    .flag_clr(flag_clr), .cmp_flag(cmp_flag), .oc_state(oc_state)
  );

  assign pin_ovr = |mode;
endmodule

// File: rtl/tmr_ocu_chk.sv
module tmr_ocu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_wr,
  input logic         cmp_wr,
  input logic [W-1:0] cmp_wdata,
  input logic         force_stb,
  input logic         pwm_mode,
  input logic         update_stb,
  input logic [1:0]   mode,
  input logic         flag_clr,
  input logic         cmp_flag,
  input logic         oc_state,
  input logic [W-1:0] act_cmp,
  input logic         hit
);
  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_flag && !flag_clr |=> cmp_flag);
  // R3
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !hit |=> !cmp_flag);
  // R4
  cnt_wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr && !cmp_flag |=> !cmp_flag);
  // R6
  force_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_stb && !hit && !cmp_flag |=> !cmp_flag);
  // R5
  set_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && mode == 2'b11 |=> oc_state);
  // R5
  clr_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && mode == 2'b10 |=> !oc_state);
  // R5
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |=> $stable(oc_state));
  // R7
  direct_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_mode && cmp_wr |=> act_cmp == $past(cmp_wdata));
  // R8
  pwm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_mode && !update_stb |=> $stable(act_cmp));
endmodule

bind tmr_ocu tmr_ocu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_i), .cnt_wr(cnt_wr), .cmp_wr(cmp_wr),
  .cmp_wdata(cmp_wdata), .force_stb(force_stb), .pwm_mode(pwm_mode),
  .update_stb(update_stb), .mode(mode), .flag_clr(flag_clr),
  .cmp_flag(cmp_flag), .oc_state(oc_state), .act_cmp(act_cmp), .hit(hit)
);

// File: tb/tmr_ocu_tb.sv
module tmr_ocu_tb;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, cnt_wr = 0, cmp_wr = 0, force_stb = 0, pwm_mode = 0;
  logic update_stb = 0, flag_clr = 0;
  logic [W-1:0] cnt_val = '0, cmp_wdata = '0;
  logic [1:0] mode = 2'b00;
  logic cmp_flag, oc_state, pin_ovr;

  int total = 0, bad = 0, cycles = 0;
  logic [W-1:0] m_act = '0, m_buf = '0;
  logic m_blk = 0, m_flag = 0, m_oc = 0;

  always #10 clk = ~clk;

  tmr_ocu #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_val(cnt_val), .cnt_wr(cnt_wr),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .force_stb(force_stb),
    .pwm_mode(pwm_mode), .update_stb(update_stb), .mode(mode),
    .flag_clr(flag_clr), .cmp_flag(cmp_flag), .oc_state(oc_state),
    .pin_ovr(pin_ovr)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic apply(input logic oc, input logic [1:0] md);
    case (md)
      2'b01: return ~oc;
      2'b10: return 1'b0;
      2'b11: return 1'b1;
      default: return oc;
    endcase
  endfunction

  task automatic step(input logic tk, input logic [W-1:0] cv, input logic cw,
                      input logic wr, input logic [W-1:0] wd, input logic frc,
                      input logic pwm, input logic upd, input logic [1:0] md,
                      input logic clr, input string tag);
    logic hit, fire;
    @(negedge clk);
    tick = tk; cnt_val = cv; cnt_wr = cw; cmp_wr = wr; cmp_wdata = wd;
    force_stb = frc; pwm_mode = pwm; update_stb = upd; mode = md; flag_clr = clr;
    #1;
    chk(pin_ovr, md != 2'b00, "R9");
    hit  = tk && (cv == m_act) && !m_blk && !cw;
    fire = hit || (frc && !pwm);
    if (fire) m_oc = apply(m_oc, md);
    else if (pwm && upd) begin
      if (md == 2'b10) m_oc = 1'b1;
      else if (md == 2'b11) m_oc = 1'b0;
    end
    if (hit) m_flag = 1'b1; else if (clr) m_flag = 1'b0;
    m_blk = cw | (m_blk & ~tk);
    if (pwm) begin
      if (upd) m_act = m_buf;
    end else if (wr) m_act = wd;
    if (wr) m_buf = wd;
    @(posedge clk); #2;
    chk(cmp_flag, m_flag, {tag, " flag"});
    chk(oc_state, m_oc, {tag, " oc"});
  endtask

  task automatic idle(input logic pwm, input logic [1:0] md, input string tag);
    step(0, 8'hFF, 0, 0, 0, 0, pwm, 0, md, 0, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(cmp_flag, 1'b0, "R1 flag");
    chk(oc_state, 1'b0, "R1 oc");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: active compare is 0 -> tick at count 0 matches
    step(1, 0, 0, 0, 0, 0, 0, 0, 2'b00, 0, "R1 zero");
    chk(cmp_flag, 1'b1, "R1 cmp0");
    step(0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 1, "R3 clr");
    // R7 direct write, then R2 match
    step(0, 0, 0, 1, 8'd5, 0, 0, 0, 2'b11, 0, "R7 wr");
    step(1, 5, 0, 0, 0, 0, 0, 0, 2'b11, 0, "R2 R7 match");
    chk(oc_state, 1'b1, "R5 set");
    // R3 hold and clear+match
    idle(0, 2'b11, "R3 hold");
    step(1, 5, 0, 0, 0, 0, 0, 0, 2'b10, 1, "R3 clr+match");
    chk(cmp_flag, 1'b1, "R3 set wins");
    chk(oc_state, 1'b0, "R5 clear");
    step(0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 1, "R3 clr2");
    // R4 block: same cycle, then across idle cycles
    step(1, 5, 1, 0, 0, 0, 0, 0, 2'b01, 0, "R4 same");
    step(0, 5, 0, 0, 0, 0, 0, 0, 2'b01, 0, "R4 idle");
    step(1, 5, 0, 0, 0, 0, 0, 0, 2'b01, 0, "R4 next tick");
    chk(cmp_flag, 1'b0, "R4 blocked");
    step(1, 5, 0, 0, 0, 0, 0, 0, 2'b01, 0, "R4 released");
    chk(cmp_flag, 1'b1, "R4 match after");
    step(0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 1, "R3 clr3");
    // R6 force
    step(0, 0, 0, 0, 0, 1, 0, 0, 2'b01, 0, "R6 force");
    chk(cmp_flag, 1'b0, "R6 no flag");
    step(1, 5, 0, 0, 0, 1, 0, 0, 2'b01, 0, "R6 force+match");
    step(0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 1, "R3 clr4");
    step(0, 0, 0, 0, 0, 1, 1, 0, 2'b01, 0, "R6 pwm ignored");
    // R8 buffered
    step(0, 0, 0, 1, 8'd9, 0, 1, 0, 2'b10, 0, "R8 buf wr");
    step(1, 9, 0, 0, 0, 0, 1, 0, 2'b10, 0, "R8 no early");
    chk(cmp_flag, 1'b0, "R8 old active");
    step(0, 0, 0, 1, 8'd3, 0, 1, 1, 2'b10, 0, "R8 R10 upd+wr");
    step(1, 9, 0, 0, 0, 0, 1, 0, 2'b10, 0, "R8 new active");
    chk(cmp_flag, 1'b1, "R8 matched");
    step(1, 9, 0, 0, 0, 0, 1, 1, 2'b11, 1, "R10 match wins");
    step(0, 0, 0, 0, 0, 0, 1, 1, 2'b11, 1, "R10 upd clr");
    // R11 mode switch
    step(0, 0, 0, 0, 0, 0, 0, 0, 2'b11, 0, "R11 to nonpwm");
    step(0, 0, 0, 0, 0, 0, 0, 1, 2'b10, 0, "R7 upd ignored");
    step(0, 0, 0, 0, 0, 0, 1, 1, 2'b10, 0, "R10 upd set");
    step(0, 0, 0, 0, 0, 0, 0, 0, 2'b10, 0, "R11 back");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 3) != 0, W'($urandom_range(0, 7)),
           $urandom_range(0, 9) == 0, $urandom_range(0, 7) == 0,
           W'($urandom_range(0, 7)), $urandom_range(0, 5) == 0,
           $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0,
           2'($urandom_range(0, 3)), $urandom_range(0, 3) == 0, "R2 rnd");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule